// File: doc/BRIEF.md
# Scan-Priority Memory Slot Arbiter

This block decides which of seventeen requesters owns a single shared memory in each memory cycle. Sixteen of them are I/O channel buffers, eight on the output side and eight on the input side. The seventeenth is the processor. Every decision restarts from the top of a fixed priority order. The first requester with work pending wins. Requesters that have nothing to do cost no time.

An I/O winner holds the memory for a whole buffer slot, which is `SLOT_CYC` memory cycles. The processor holds it for a single cycle. The processor takes every cycle that no I/O channel claims. When a channel runs in distributed mode and its word is an end-of-item word, it receives a double slot.

Each I/O demand is timed from the moment it is captured. If it is not served within `DEADLINE` cycles, a one-cycle error pulse is raised for that channel. The channel then knows that the word was lost and must be fetched again.

Top module: `scan_mem_arbiter`

## Requirements
- R1: `grant` is one-hot or zero. Bit i belongs to stage i: bits 0-7 are the output channels, bits 8-15 the input channels, and bit 16 the processor. `busy` is high exactly when a grant bit is high.
- R2: At every slot boundary, the pending I/O stage with the lowest index wins. The processor (bit 16) wins only when no I/O stage is pending.
- R3: An I/O grant stays unchanged for `SLOT_CYC` consecutive cycles (default 3) and cannot be pre-empted. A demand that arrives during a slot is considered only at the next boundary.
- R4: A processor grant lasts one cycle. While `cpu_req` is high and no I/O stage is pending, the processor is granted in every cycle.
- R5: Each I/O demand is captured on the rising edge of its `io_req` bit, one clock after that edge. It is served exactly once. A level that stays high after its grant earns no further slot.
- R6: If a stage has both its `io_dist` and `io_eoi` bits high at the edge that grants it, it holds the memory for 2×`SLOT_CYC` cycles. Either bit alone gives a normal slot.
- R7: A captured demand that is still ungranted 62 (`DEADLINE`) clock edges after the edge that captured it raises its `dl_err` bit for exactly one cycle. The demand stays pending and is served later. A demand granted by that edge raises no error.
- R8: After reset there is no grant, `busy` is low, and no error is raised.
- R9: With no demand at all, `grant` is zero and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 16 | I/O demand lines, bits 0-7 output channels, 8-15 input channels |
| io_eoi | input | 16 | End-of-item marker that accompanies each demand |
| io_dist | input | 16 | Distributed-mode flag of each channel |
| cpu_req | input | 1 | Processor demand, high while any program runs |
| grant | output | 17 | One-hot owner of the current memory cycle |
| busy | output | 1 | Memory is owned this cycle |
| dl_err | output | 16 | One-cycle missed-deadline pulse per I/O stage |

## Verification
The bench raises two channels and the processor together, to check that the lowest index wins and that the processor comes last. A design that rotated priority, or favoured the processor, would grant in the wrong order.

It raises a top-priority demand in the middle of another channel's slot. A pre-empting arbiter would cut that slot short.

It holds a demand level high after its grant. A level-sensitive design would hand that channel repeated slots.

It fills all sixteen channels with double-slot demands so that the last five channels run past their deadline. The bench then checks the exact cycle of the error pulse and which channels carry it. An off-by-one deadline counter would fire a cycle early or late, or flag channel 10, which was served just in time.

// File: rtl/scan_mem_arbiter.sv
module scan_mem_arbiter #(
  parameter int NIO      = 16,
  parameter int SLOT_CYC = 3,
  parameter int DEADLINE = 62
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NIO-1:0] io_req,
  input  logic [NIO-1:0] io_eoi,
  input  logic [NIO-1:0] io_dist,
  input  logic           cpu_req,
  output logic [NIO:0]   grant,
  output logic           busy,
  output logic [NIO-1:0] dl_err
);
  localparam int CW = $clog2(2 * SLOT_CYC) + 1;
  localparam int DW = $clog2(DEADLINE + 1);

  logic [NIO-1:0] req_q, pend, take, rise;
  logic [NIO:0]   pick;
  logic [CW-1:0]  cnt;
  logic           bnd;

  assign bnd  = (cnt == '0);
  assign rise = io_req & ~req_q;
  assign take = bnd ? pick[NIO-1:0] : '0;
  assign busy = |grant;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NIO; i++)
      if (pend[i] && pick == '0) pick[i] = 1'b1;
    if (pick == '0 && cpu_req) pick[NIO] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
      grant <= '0;
      cnt   <= '0;
    end else begin
      req_q <= io_req;
      pend  <= (pend & ~take) | rise;
      if (bnd) begin
        grant <= pick;
        if (|pick[NIO-1:0])
          cnt <= |(pick[NIO-1:0] & io_dist & io_eoi) ? CW'(2 * SLOT_CYC - 1)
                                                     : CW'(SLOT_CYC - 1);
        else
          cnt <= '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NIO; g++) begin : g_dl
    logic [DW-1:0] dl;
    logic          err;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dl  <= '0;
        err <= 1'b0;
      end else begin
        err <= 1'b0;
        if (rise[g]) begin
          dl <= DW'(DEADLINE);
        end else if (pend[g] && !take[g] && dl != '0) begin
          dl <= dl - 1'b1;
          if (dl == DW'(1)) err <= 1'b1;
        end
      end
    end
    assign dl_err[g] = err;
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R1
  AST_CPU_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    grant[NIO] |-> $past(pend) == '0); // R2
  AST_ERR_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_err & ~pend) == '0); // R7
  AST_ERR_NOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_err & grant[NIO-1:0]) == '0); // R7

  if (SLOT_CYC > 1) begin : g_hold
    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (|(grant[NIO-1:0] & ~$past(grant[NIO-1:0]))) |=> $stable(grant)); // R3
  end
endmodule

// File: tb/sim_scan_mem_arbiter.sv
module sim_scan_mem_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_req = '0, io_eoi = '0, io_dist = '0;
  logic        cpu_req = 1'b0;
  logic [16:0] grant;
  logic        busy;
  logic [15:0] dl_err;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scan_mem_arbiter u0 (.clk, .rst_n, .io_req, .io_eoi, .io_dist, .cpu_req,
                       .grant, .busy, .dl_err);

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk("R8 grant", 32'(grant), 0);
    chk("R8 busy", 32'(busy), 0);
    chk("R8 err", 32'(dl_err), 0);
    rst_n = 1'b1;
    tick(3);
    chk("R9 idle grant", 32'(grant), 0);
    chk("R9 idle busy", 32'(busy), 0);
  endtask

  task automatic t_single;
    io_req[3] = 1'b1;
    tick(2);
    chk("R1 grant stage3", 32'(grant), 32'h8);
    chk("R1 busy", 32'(busy), 1);
    tick(1); chk("R3 hold c2", 32'(grant), 32'h8);
    tick(1); chk("R3 hold c3", 32'(grant), 32'h8);
    for (int k = 0; k < 5; k++) begin
      tick(1); chk("R5 level no regrant", 32'(grant), 0);
    end
    io_req[3] = 1'b0;
    tick(2);
  endtask

  task automatic t_priority;
    io_req[9] = 1'b1; io_req[2] = 1'b1; cpu_req = 1'b1;
    tick(1); chk("R4 cpu before capture", 32'(grant), 32'h10000);
    tick(1); chk("R2 lowest first", 32'(grant), 32'h4);
    tick(3); chk("R2 next stage9", 32'(grant), 32'h200);
    tick(3); chk("R2 cpu last", 32'(grant), 32'h10000);
    tick(1); chk("R4 cpu every cycle", 32'(grant), 32'h10000);
    io_req[9] = 1'b0; io_req[2] = 1'b0;
    io_req[15] = 1'b1;
    tick(1); chk("R4 cpu one cycle", 32'(grant), 32'h10000);
    tick(1); chk("R4 io after cpu", 32'(grant), 32'h8000);
    io_req[15] = 1'b0; cpu_req = 1'b0;
    tick(4);
    chk("R9 idle again", 32'(busy), 0);
  endtask

  task automatic t_nopreempt;
    io_req[10] = 1'b1;
    tick(2); chk("R3 grant10", 32'(grant), 32'h400);
    io_req[0] = 1'b1;
    tick(1); chk("R3 no preempt c2", 32'(grant), 32'h400);
    tick(1); chk("R3 no preempt c3", 32'(grant), 32'h400);
    tick(1); chk("R3 boundary stage0", 32'(grant), 32'h1);
    io_req[0] = 1'b0; io_req[10] = 1'b0;
    tick(4);
  endtask

  task automatic t_double;
    io_req[4] = 1'b1; io_dist[4] = 1'b1; io_eoi[4] = 1'b1;
    tick(2);
    for (int k = 0; k < 6; k++) begin
      chk("R6 double slot", 32'(grant), 32'h10);
      tick(1);
    end
    chk("R6 double ends", 32'(grant), 0);
    io_req[4] = 1'b0; io_eoi[4] = 1'b0; io_dist[4] = 1'b0;
    io_req[5] = 1'b1; io_dist[5] = 1'b1;
    tick(4);
    chk("R6 dist only normal", 32'(grant), 32'h20);
    tick(1);
    chk("R6 dist only ends", 32'(grant), 0);
    io_req[5] = 1'b0; io_dist[5] = 1'b0;
    tick(3);
  endtask

  task automatic t_deadline;
    int pulses15 = 0;
    io_dist = '1; io_eoi = '1; io_req = '1;
    for (int n = 1; n <= 98; n++) begin
      tick(1);
      if (dl_err[15]) pulses15++;
      if (n == 62) chk("R7 no early error", 32'(dl_err), 0);
      if (n == 63) chk("R7 late stages flagged", 32'(dl_err), 32'hF800);
      if (n == 64) chk("R7 single pulse", 32'(dl_err), 0);
      if (n == 62) chk("R7 stage10 in time", 32'(grant), 32'h400);
      if (n == 92) chk("R7 late grant still served", 32'(grant), 32'h8000);
      if (n == 98) chk("R6 last double ends", 32'(grant), 0);
    end
    chk("R7 one pulse per demand", 32'(pulses15), 1);
    io_req = '0; io_dist = '0; io_eoi = '0;
    tick(3);
  endtask

  initial begin
    tick(2);
    t_reset;
    t_single;
    t_priority;
    t_nopreempt;
    t_double;
    t_deadline;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule